// File: doc/BRIEF.md
# Weighted Reservation Bandwidth Regulator

This block shares one grant slot per clock cycle among several QoS register interfaces (QRIs) of a bandwidth controller. Time is cut into accounting intervals of a fixed number of cycles, so each interval holds that many grant slots. Every QRI owns a reserved slot budget and a share weight, both set through a configuration port. While a requesting QRI is still below its reserved budget for the current interval, it is served first. Slots that no reservation claims are then handed out by weight. Only QRIs that are requesting and have a nonzero weight take part in that second round.

A QRI with weight zero is capped hard at its reservation. Excess slots go out through a credit-based weighted round robin. Each QRI's credit is loaded with its weight at every interval boundary, and the credits are reloaded whenever no contender has credit left. The configuration port refuses any change that would raise the sum of all reservations above the number of slots in one interval. The programmed reservation and weight of each QRI can always be read back on the capability outputs.

Top module: `qbw_regulator`

## Requirements
- R1: After reset every reservation and weight reads back as zero, `cfg_ack` is low, and no request is granted until a reservation or a weight is configured.
- R2: In any cycle at most one bit of `gnt` is high, and only for a QRI whose `req` bit is high. The grant is combinational from `req` in the same cycle.
- R3: If any requesting QRI has received fewer grants than its reservation in the current interval, the grant goes to the lowest-numbered such QRI, ahead of any weighted sharing.
- R4: A QRI with weight zero receives at most its reservation in grants within one interval, even when no other QRI requests.
- R5: Allocation is work-conserving. When a requester is under its reservation, or has nonzero weight, some QRI is granted in that cycle.
- R6: Once no requester is under its reservation, slots go to requesters with nonzero weight. Among those with credit left, the lowest-numbered one is granted and its credit drops by one. When no contender has credit left, every credit is reloaded with its weight before the choice is made. With weights 2 and 1 this gives the repeating order A, A, B.
- R7: Intervals are `INTERVAL` cycles long and start at the first cycle after reset. At each boundary all per-QRI grant counts clear and every credit is reloaded with its weight.
- R8: A `cfg_valid` cycle is followed by one cycle of `cfg_ack`. If accepted, `cfg_err` is low and the capability outputs show the new reservation and weight for `cfg_qrid` in that cycle. Reservation of QRI i sits at bits [i*RW +: RW] of `cap_rbwb`, and weight at [i*WW +: WW] of `cap_weight`.
- R9: A configuration whose reservation, added to the other QRIs' reservations, exceeds `INTERVAL` is rejected. `cfg_ack` and `cfg_err` are high together and the capability outputs stay unchanged. A sum exactly equal to `INTERVAL` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NQ | Per-QRI request, one bit per QRI |
| gnt | output | NQ | Per-QRI grant for the current slot, at most one hot |
| cfg_valid | input | 1 | Limit operation strobe |
| cfg_qrid | input | QW | Target QRI of the limit operation |
| cfg_rbwb | input | RW | Reserved slots per interval for the target |
| cfg_weight | input | WW | Share weight for the target |
| cfg_ack | output | 1 | Completion of a limit operation, one cycle after the strobe |
| cfg_err | output | 1 | Rejection because of reservation overcommit, valid with cfg_ack |
| cap_rbwb | output | NQ*RW | Programmed reservation of each QRI |
| cap_weight | output | NQ*WW | Programmed weight of each QRI |

## Verification
A wrong grant counter or credit value first shows up as a `gnt` bit going to the wrong QRI. This happens in the first cycle where the order of the reservation pass or of the credit round differs from the rules. For the excess split, that is within one weight round. A counter that fails to clear at a boundary shows up within one interval, because a zero-weight QRI then falls silent early, and per-interval grant totals catch it. A faulty overcommit sum shows up on `cfg_err` and on the capability outputs in the cycle right after the offending configuration.

// File: rtl/qbw_pkg.sv
package qbw_pkg;

    typedef enum logic {
        CFG_OK         = 1'b0,
        CFG_OVERCOMMIT = 1'b1
    } cfg_status_e;

    typedef struct packed {
        logic        ack;
        cfg_status_e status;
    } cfg_resp_t;

    function automatic logic [31:0] lowest_one(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

endpackage

// File: rtl/qbw_interval.sv
module qbw_interval #(
    parameter int INTERVAL = 16
) (
    input  logic clk,
    input  logic rst,
    output logic boundary
);
    localparam int SLW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [SLW-1:0] slot_q;

    assign boundary = (slot_q == SLW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst)           slot_q <= '0;
        else if (boundary) slot_q <= '0;
        else               slot_q <= slot_q + SLW'(1);
    end
endmodule

// File: rtl/qbw_cfg_regs.sv
module qbw_cfg_regs
    import qbw_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int INTERVAL = 16,
    parameter int RW       = 5,
    parameter int WW       = 4,
    parameter int QW       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_valid,
    input  logic [QW-1:0]          cfg_qrid,
    input  logic [RW-1:0]          cfg_rbwb,
    input  logic [WW-1:0]          cfg_weight,
    output cfg_resp_t              resp,
    output logic [NQ-1:0][RW-1:0]  rbwb,
    output logic [NQ-1:0][WW-1:0]  weight
);
    localparam int SW = RW + QW + 1;

    logic [NQ-1:0][RW-1:0] rbwb_q;
    logic [NQ-1:0][WW-1:0] weight_q;
    logic [SW-1:0]         others_sum;
    logic [SW-1:0]         new_total;
    logic                  fits;
    cfg_resp_t             resp_q;

    always_comb begin
        others_sum = '0;
        for (int i = 0; i < NQ; i++) begin
            if (QW'(i) != cfg_qrid) others_sum = others_sum + SW'(rbwb_q[i]);
        end
        new_total = others_sum + SW'(cfg_rbwb);
        fits      = (new_total <= SW'(INTERVAL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbwb_q   <= '0;
            weight_q <= '0;
            resp_q   <= '{ack: 1'b0, status: CFG_OK};
        end else begin
            resp_q.ack <= cfg_valid;
            if (cfg_valid) begin
                resp_q.status <= fits ? CFG_OK : CFG_OVERCOMMIT;
                if (fits) begin
                    rbwb_q[cfg_qrid]   <= cfg_rbwb;
                    weight_q[cfg_qrid] <= cfg_weight;
                end
            end
        end
    end

    assign resp   = resp_q;
    assign rbwb   = rbwb_q;
    assign weight = weight_q;
endmodule

// File: rtl/qbw_arbiter.sv
module qbw_arbiter
    import qbw_pkg::*;
#(
    parameter int NQ = 4,
    parameter int RW = 5,
    parameter int WW = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boundary,
    input  logic [NQ-1:0]         req,
    input  logic [NQ-1:0][RW-1:0] rbwb,
    input  logic [NQ-1:0][WW-1:0] weight,
    output logic [NQ-1:0]         gnt
);
    logic [NQ-1:0][RW-1:0] used_q;
    logic [NQ-1:0][WW-1:0] credit_q;
    logic [NQ-1:0][WW-1:0] eff_credit;
    logic [NQ-1:0]         under_res;
    logic [NQ-1:0]         contender;
    logic [NQ-1:0]         has_credit;
    logic [NQ-1:0]         eff_nz;
    logic [NQ-1:0]         cand;
    logic                  reload;
    logic                  res_phase;
    logic [31:0]           pick;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            under_res[i]  = req[i] && (used_q[i] < rbwb[i]);
            contender[i]  = req[i] && (weight[i] != '0);
            has_credit[i] = contender[i] && (credit_q[i] != '0);
        end
        reload    = ~|has_credit;
        res_phase = |under_res;
        for (int i = 0; i < NQ; i++) begin
            eff_credit[i] = reload ? weight[i] : credit_q[i];
            eff_nz[i]     = contender[i] && (eff_credit[i] != '0);
        end
        cand = res_phase ? under_res : eff_nz;
        pick = lowest_one(32'(cand));
        gnt  = pick[NQ-1:0];
    end

    for (genvar g = 0; g < NQ; g++) begin : g_qri
        always_ff @(posedge clk) begin
            if (rst) begin
                used_q[g]   <= '0;
                credit_q[g] <= '0;
            end else if (boundary) begin
                used_q[g]   <= '0;
                credit_q[g] <= weight[g];
            end else begin
                if (gnt[g] && (used_q[g] != '1)) used_q[g] <= used_q[g] + RW'(1);
                if (!res_phase) begin
                    credit_q[g] <= gnt[g] ? eff_credit[g] - WW'(1) : eff_credit[g];
                end
            end
        end
    end
endmodule

// File: rtl/qbw_regulator.sv
module qbw_regulator
    import qbw_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int INTERVAL = 16,
    parameter int WW       = 4,
    parameter int RW       = $clog2(INTERVAL + 1),
    parameter int QW       = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NQ-1:0]    req,
    output logic [NQ-1:0]    gnt,
    input  logic             cfg_valid,
    input  logic [QW-1:0]    cfg_qrid,
    input  logic [RW-1:0]    cfg_rbwb,
    input  logic [WW-1:0]    cfg_weight,
    output logic             cfg_ack,
    output logic             cfg_err,
    output logic [NQ*RW-1:0] cap_rbwb,
    output logic [NQ*WW-1:0] cap_weight
);
    logic                  boundary;
    cfg_resp_t             resp;
    logic [NQ-1:0][RW-1:0] rbwb;
    logic [NQ-1:0][WW-1:0] weight;

    qbw_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary)
    );

    qbw_cfg_regs #(
        .NQ(NQ), .INTERVAL(INTERVAL), .RW(RW), .WW(WW), .QW(QW)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_valid  (cfg_valid),
        .cfg_qrid   (cfg_qrid),
        .cfg_rbwb   (cfg_rbwb),
        .cfg_weight (cfg_weight),
        .resp       (resp),
        .rbwb       (rbwb),
        .weight     (weight)
    );

    qbw_arbiter #(.NQ(NQ), .RW(RW), .WW(WW)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .req      (req),
        .rbwb     (rbwb),
        .weight   (weight),
        .gnt      (gnt)
    );

    assign cfg_ack    = resp.ack;
    assign cfg_err    = resp.ack && (resp.status == CFG_OVERCOMMIT);
    assign cap_rbwb   = rbwb;
    assign cap_weight = weight;
endmodule

// File: rtl/qbw_regulator_chk.sv
module qbw_regulator_chk #(
    parameter int NQ       = 4,
    parameter int INTERVAL = 16,
    parameter int WW       = 4,
    parameter int RW       = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [NQ-1:0]    req,
    input logic [NQ-1:0]    gnt,
    input logic             cfg_valid,
    input logic             cfg_ack,
    input logic             cfg_err,
    input logic [NQ*RW-1:0] cap_rbwb,
    input logic [NQ*WW-1:0] cap_weight
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0]         tick_q;
    logic                  edge_now;
    logic                  touched_q;
    logic [NQ-1:0][RW-1:0] seen_q;

    assign edge_now = (tick_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q    <= '0;
            touched_q <= 1'b0;
            seen_q    <= '0;
        end else begin
            tick_q    <= edge_now ? '0 : tick_q + CW'(1);
            touched_q <= edge_now ? 1'b0 : (touched_q || (cfg_ack && !cfg_err));
            for (int i = 0; i < NQ; i++) begin
                if (edge_now)                       seen_q[i] <= '0;
                else if (gnt[i] && seen_q[i] != '1) seen_q[i] <= seen_q[i] + RW'(1);
            end
        end
    end

    // R2
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    // R2
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    // R8
    a_r8_ack_follows: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> cfg_ack);
    // R8
    a_r8_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> !cfg_ack);
    // R8
    a_r8_cap_moves_on_ack: assert property (@(posedge clk) disable iff (rst)
        !cfg_ack |-> ($stable(cap_rbwb) && $stable(cap_weight)));
    // R9
    a_r9_reject_keeps_cap: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> ($stable(cap_rbwb) && $stable(cap_weight)));

    for (genvar g = 0; g < NQ; g++) begin : g_cap
        // R4
        a_r4_zero_weight_cap: assert property (@(posedge clk) disable iff (rst)
            (gnt[g] && cap_weight[g*WW +: WW] == '0 && !touched_q && !(cfg_ack && !cfg_err))
            |-> (seen_q[g] < cap_rbwb[g*RW +: RW]));
    end
endmodule

bind qbw_regulator qbw_regulator_chk #(
    .NQ(NQ), .INTERVAL(INTERVAL), .WW(WW), .RW(RW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .gnt        (gnt),
    .cfg_valid  (cfg_valid),
    .cfg_ack    (cfg_ack),
    .cfg_err    (cfg_err),
    .cap_rbwb   (cap_rbwb),
    .cap_weight (cap_weight)
);

// File: tb/qbw_regulator_tb.sv
module qbw_regulator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;
    localparam int INTERVAL = 16;
    localparam int WW = 4;
    localparam int RW = $clog2(INTERVAL + 1);
    localparam int QW = $clog2(NQ);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NQ-1:0]    req = '0;
    logic [NQ-1:0]    gnt;
    logic             cfg_valid = 1'b0;
    logic [QW-1:0]    cfg_qrid = '0;
    logic [RW-1:0]    cfg_rbwb = '0;
    logic [WW-1:0]    cfg_weight = '0;
    logic             cfg_ack;
    logic             cfg_err;
    logic [NQ*RW-1:0] cap_rbwb;
    logic [NQ*WW-1:0] cap_weight;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_used [NQ];
    int m_cr   [NQ];
    int m_rb   [NQ];
    int m_w    [NQ];
    int m_slot = 0;
    int seen_cnt [NQ];

    logic [NQ-1:0] exp_q [$];
    string         tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qbw_regulator #(.NQ(NQ), .INTERVAL(INTERVAL), .WW(WW)) dut_i (
        .clk(clk), .rst(rst), .req(req), .gnt(gnt),
        .cfg_valid(cfg_valid), .cfg_qrid(cfg_qrid), .cfg_rbwb(cfg_rbwb),
        .cfg_weight(cfg_weight), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
        .cap_rbwb(cap_rbwb), .cap_weight(cap_weight)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected grants and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [NQ-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(gnt), int'(e));
                for (int i = 0; i < NQ; i++) if (gnt[i]) seen_cnt[i]++;
            end
        end
    end

    // driver: one cycle of stimulus plus the reference model
    task automatic step(input logic [NQ-1:0] r, input string tag,
                        input bit cv = 0, input int cq = 0, input int crb = 0, input int cw = 0);
        logic [NQ-1:0] e;
        bit res_any;
        bit reload;
        int eff [NQ];
        int win;
        int sum;
        @(negedge clk);
        req = r; cfg_valid = cv; cfg_qrid = QW'(cq); cfg_rbwb = RW'(crb); cfg_weight = WW'(cw);
        e = '0; win = -1; res_any = 0; reload = 1;
        for (int i = 0; i < NQ; i++) if (r[i] && m_used[i] < m_rb[i]) res_any = 1;
        for (int i = 0; i < NQ; i++) if (r[i] && m_w[i] != 0 && m_cr[i] != 0) reload = 0;
        for (int i = 0; i < NQ; i++) eff[i] = reload ? m_w[i] : m_cr[i];
        for (int i = NQ-1; i >= 0; i--) begin
            if (res_any) begin
                if (r[i] && m_used[i] < m_rb[i]) win = i;
            end else if (r[i] && m_w[i] != 0 && eff[i] != 0) win = i;
        end
        if (win >= 0) e[win] = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        if (m_slot == INTERVAL - 1) begin
            m_slot = 0;
            for (int i = 0; i < NQ; i++) begin m_used[i] = 0; m_cr[i] = m_w[i]; end
        end else begin
            m_slot++;
            if (win >= 0) m_used[win]++;
            if (!res_any) begin
                for (int i = 0; i < NQ; i++) m_cr[i] = eff[i];
                if (win >= 0) m_cr[win]--;
            end
        end
        if (cv) begin
            sum = crb;
            for (int i = 0; i < NQ; i++) if (i != cq) sum += m_rb[i];
            if (sum <= INTERVAL) begin m_rb[cq] = crb; m_w[cq] = cw; end
        end
        #1;
        cfg_valid = 1'b0;
    endtask

    task automatic configure(input int q, input int rb, input int w, input bit expect_err,
                             input string tag);
        step('0, tag, 1, q, rb, w);
        check({tag, " ack"}, int'(cfg_ack), 1);
        check({tag, " err"}, int'(cfg_err), int'(expect_err));
        for (int i = 0; i < NQ; i++) begin
            check({tag, " cap rbwb"}, int'(cap_rbwb[i*RW +: RW]), m_rb[i]);
            check({tag, " cap weight"}, int'(cap_weight[i*WW +: WW]), m_w[i]);
        end
    endtask

    task automatic align();
        while (m_slot != 0) step('0, "R7 idle");
    endtask

    task automatic run_interval(input logic [NQ-1:0] r, input string tag);
        align();
        for (int i = 0; i < NQ; i++) seen_cnt[i] = 0;
        for (int k = 0; k < INTERVAL; k++) step(r, tag);
    endtask

    initial begin
        for (int i = 0; i < NQ; i++) begin m_used[i] = 0; m_cr[i] = 0; m_rb[i] = 0; m_w[i] = 0; seen_cnt[i] = 0; end
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        m_slot = 0;
        // R1 reset state
        check("R1 ack after reset", int'(cfg_ack), 0);
        check("R1 cap rbwb after reset", int'(cap_rbwb), 0);
        check("R1 cap weight after reset", int'(cap_weight), 0);
        for (int k = 0; k < 6; k++) step('1, "R1 no grant unconfigured");

        // R8 accepted configurations
        configure(0, 4, 0, 0, "R8 cfg q0");
        configure(1, 4, 2, 0, "R8 cfg q1");
        configure(2, 2, 1, 0, "R8 cfg q2");
        configure(3, 2, 0, 0, "R8 cfg q3");
        // R9 overcommit rejected, exact fit accepted
        configure(3, 10, 5, 1, "R9 overcommit");
        configure(3, 6, 0, 0, "R9 exact fit");
        configure(3, 2, 0, 0, "R8 restore q3");

        // R4 zero-weight hard cap when alone
        run_interval(4'b0001, "R4 q0 alone");
        check("R4 q0 grants per interval", seen_cnt[0], 4);
        run_interval(4'b1000, "R4 q3 alone");
        check("R4 q3 grants per interval", seen_cnt[3], 2);
        // R5 work conserving for weighted QRI
        run_interval(4'b0010, "R5 q1 alone");
        check("R5 q1 takes all slots", seen_cnt[1], INTERVAL);
        // R6 weighted split 2:1 after reservations
        run_interval(4'b0110, "R6 q1 q2 split");
        check("R6 q1 share", seen_cnt[1], 11);
        check("R6 q2 share", seen_cnt[2], 5);
        // R3 reservation first, lowest QRID
        run_interval(4'b1111, "R3 all request");
        check("R3 q0 share", seen_cnt[0], 4);
        check("R3 q3 share", seen_cnt[3], 2);
        check("R3 q1 share", seen_cnt[1], 7);
        check("R3 q2 share", seen_cnt[2], 3);
        // R7 counts clear each interval: second interval repeats
        run_interval(4'b0001, "R7 q0 again");
        check("R7 q0 second interval", seen_cnt[0], 4);

        // R2/R3/R6 mixed patterns with reconfiguration
        begin
            logic [7:0] lfsr = 8'hA5;
            for (int k = 0; k < 300; k++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                if (k == 120) configure(2, 3, 3, 0, "R8 cfg q2 mid");
                else if (k == 200) configure(0, 1, 1, 0, "R8 cfg q0 mid");
                else step(lfsr[3:0], "R2 R3 R6 mixed");
            end
        end
        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule